// File: doc/BRIEF.md
# Serial Step-Attenuator Control Port

This block is the receive side of a three-wire control port (serial clock, serial data, enable) that programs a binary-weighted step attenuator. Enable is held low while a host clocks in an eight-bit programming word, most significant bit first. One bit is captured on each rising edge of the serial clock.

When enable returns high, the low six bits of the word are moved into a holding latch. Each latched bit drives one attenuator section, with weights of 1, 2, 4, 8, 16 and 32 dB. A set bit switches its section into the path, and a clear bit bypasses it. The two upper bits of the word are discarded.

All three serial lines are sampled by a faster system clock through two-flop synchronizers. The block also reports the total programmed attenuation in dB and raises a flag when that total is outside the usable 0 to 58 dB range. A sticky error flag records any enable window that did not carry exactly eight clocks.

Top module: `sat_serial_ctrl`

## Requirements
- R1: After reset, all sections are bypassed: stage_on is 0, atten_db is 0, over_range is 0 and frame_err is 0.
- R2: While ser_en is low, each rising edge of ser_clk shifts ser_dat into the word. The first bit sent ends up as bit 7 and the last bit sent as bit 0.
- R3: stage_on, atten_db and over_range change only in response to a rising edge of ser_en. They hold their values while a word is being shifted in.
- R4: After a latch, stage_on[k] equals bit k of the word for k = 0..5. A 1 switches in the section of 2^k dB, and a 0 bypasses it.
- R5: Bits 7 and 6 of the word have no effect on any output.
- R6: atten_db equals the sum of the weights of the sections that are switched in.
- R7: ser_clk edges that occur while ser_en is high neither shift the word nor change any output.
- R8: over_range is 1 exactly when atten_db is above 58. A value of 58 leaves it at 0.
- R9: If a ser_en low window carries more or fewer than eight ser_clk rising edges, the last eight bits shifted in are latched anyway, and frame_err is set. frame_err stays set until err_clr is asserted for one system clock.
- R10: Outputs update within six system clocks of the ser_en rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_clk | input | 1 | Serial clock; bits are captured on its rising edge |
| ser_dat | input | 1 | Serial data, most significant bit first |
| ser_en | input | 1 | Low during word entry; its rising edge latches the word |
| err_clr | input | 1 | Clears the sticky frame error (system clock domain) |
| stage_on | output | 6 | Per-section control; bit k switches in 2^k dB |
| atten_db | output | 6 | Total programmed attenuation in dB |
| over_range | output | 1 | Total attenuation exceeds 58 dB |
| frame_err | output | 1 | Sticky flag: a window did not carry exactly eight clocks |

## Verification
The assertions assume that each serial line stays stable for at least three system clocks between transitions. They also assume that ser_en does not rise in the same synchronized cycle as a ser_clk edge that is meant to be captured; otherwise the two-flop delay could merge or reorder edges.

The bench keeps every serial phase three system clocks long. It raises enable only after the last serial clock has fallen, and it waits several clocks after each enable edge before sampling, so every captured edge arrives unambiguously. Its expected word is kept in its own shift model, driven only by the bits it sends while enable is low.

// File: rtl/sat_pkg.sv
package sat_pkg;
    localparam int unsigned SAT_WORD_W   = 8;
    localparam int unsigned SAT_STAGES   = 6;
    localparam int unsigned SAT_MAX_DB   = 58;
    localparam int unsigned SAT_SYNC_LEN = 2;
    localparam int unsigned SAT_LINES    = 3;
endpackage

// File: rtl/sat_sync.sv
module sat_sync #(
    parameter int unsigned W       = 3,
    parameter int unsigned DEPTH   = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stage_q [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[i] <= RST_VAL;
                else        stage_q[i] <= din;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[i] <= RST_VAL;
                else        stage_q[i] <= stage_q[i-1];
            end
        end
    end

    assign dout = stage_q[DEPTH-1];
endmodule

// File: rtl/sat_shifter.sv
module sat_shifter #(
    parameter int unsigned WORD_W = 8,
    localparam int unsigned CNT_W = $clog2(WORD_W + 2)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_s,
    input  logic              dat_s,
    input  logic              en_s,
    output logic [WORD_W-1:0] word,
    output logic              en_rise,
    output logic              count_bad
);
    localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(WORD_W + 1);
    localparam logic [CNT_W-1:0] CNT_GOOD = CNT_W'(WORD_W);

    typedef struct packed {
        logic [WORD_W-1:0] sh;
        logic [CNT_W-1:0]  cnt;
        logic              sclk_p;
        logic              en_p;
    } shift_st_t;

    shift_st_t st_d, st_q;
    logic      sclk_rise;

    always_comb begin
        st_d      = st_q;
        sclk_rise = sclk_s & ~st_q.sclk_p;
        en_rise   = en_s & ~st_q.en_p;
        st_d.sclk_p = sclk_s;
        st_d.en_p   = en_s;
        if (sclk_rise && !en_s) begin
            st_d.sh = {st_q.sh[WORD_W-2:0], dat_s};
            if (st_q.cnt != CNT_MAX) st_d.cnt = st_q.cnt + 1'b1;
        end
        if (en_rise) st_d.cnt = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.sh     <= '0;
            st_q.cnt    <= '0;
            st_q.sclk_p <= 1'b0;
            st_q.en_p   <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign word      = st_q.sh;
    assign count_bad = (st_q.cnt != CNT_GOOD);

    p_shift_msb_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk_rise && !en_s) |=> (st_q.sh[0] == $past(dat_s)) &&
                                 (st_q.sh[WORD_W-1:1] == $past(st_q.sh[WORD_W-2:0])));

    p_idle_no_shift_r7: assert property (@(posedge clk) disable iff (!rst_n)
        en_s |=> $stable(st_q.sh));

    p_count_capped_r9: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CNT_MAX);
endmodule

// File: rtl/sat_latch.sv
module sat_latch #(
    parameter int unsigned WORD_W = 8,
    parameter int unsigned STAGES = 6,
    parameter int unsigned MAX_DB = 58
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [WORD_W-1:0] word,
    input  logic              bad,
    input  logic              err_clr,
    output logic [STAGES-1:0] stage_on,
    output logic [STAGES-1:0] atten_db,
    output logic              over_range,
    output logic              frame_err
);
    typedef struct packed {
        logic [STAGES-1:0] stg;
        logic              over;
        logic              err;
    } latch_st_t;

    latch_st_t st_d, st_q;
    logic [STAGES-1:0] weight_sum;

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.stg  = word[STAGES-1:0];
            st_d.over = (int'(word[STAGES-1:0]) > int'(MAX_DB));
        end
        if (err_clr)      st_d.err = 1'b0;
        if (load && bad)  st_d.err = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        weight_sum = '0;
        for (int k = 0; k < int'(STAGES); k++) begin
            if (st_q.stg[k]) weight_sum = weight_sum + STAGES'(1 << k);
        end
    end

    assign stage_on   = st_q.stg;
    assign atten_db   = weight_sum;
    assign over_range = st_q.over;
    assign frame_err  = st_q.err;

    p_latch_on_enable_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(st_q.stg));

    p_range_after_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.over) |-> $past(load));

    p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.err && !err_clr) |=> st_q.err);

    p_err_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.err) |-> $past(load && bad));
endmodule

// File: rtl/sat_serial_ctrl.sv
module sat_serial_ctrl #(
    parameter int unsigned WORD_W = sat_pkg::SAT_WORD_W,
    parameter int unsigned STAGES = sat_pkg::SAT_STAGES,
    parameter int unsigned MAX_DB = sat_pkg::SAT_MAX_DB,
    parameter int unsigned SYNC_N = sat_pkg::SAT_SYNC_LEN
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_clk,
    input  logic              ser_dat,
    input  logic              ser_en,
    input  logic              err_clr,
    output logic [STAGES-1:0] stage_on,
    output logic [STAGES-1:0] atten_db,
    output logic              over_range,
    output logic              frame_err
);
    localparam int unsigned LINES = sat_pkg::SAT_LINES;
    localparam logic [LINES-1:0] IDLE = 3'b100;

    logic [LINES-1:0]  raw_lines, sync_lines;
    logic [WORD_W-1:0] word;
    logic              en_rise, count_bad;

    assign raw_lines = {ser_en, ser_dat, ser_clk};

    sat_sync #(.W(LINES), .DEPTH(SYNC_N), .RST_VAL(IDLE)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (raw_lines),
        .dout (sync_lines)
    );

    sat_shifter #(.WORD_W(WORD_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .sclk_s   (sync_lines[0]),
        .dat_s    (sync_lines[1]),
        .en_s     (sync_lines[2]),
        .word     (word),
        .en_rise  (en_rise),
        .count_bad(count_bad)
    );

    sat_latch #(.WORD_W(WORD_W), .STAGES(STAGES), .MAX_DB(MAX_DB)) u_latch (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (en_rise),
        .word      (word),
        .bad       (count_bad),
        .err_clr   (err_clr),
        .stage_on  (stage_on),
        .atten_db  (atten_db),
        .over_range(over_range),
        .frame_err (frame_err)
    );

    p_out_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !en_rise |=> $stable(atten_db));
endmodule

// File: tb/sat_serial_ctrl_tb.sv
module sat_serial_ctrl_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ser_clk = 1'b0, ser_dat = 1'b0, ser_en = 1'b1, err_clr = 1'b0;
    logic [5:0] stage_on, atten_db;
    logic over_range, frame_err;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic [7:0] m_sh  = '0;
    logic [5:0] m_lat = '0;
    logic       m_err = 1'b0;

    always #10 clk = ~clk;

    sat_serial_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_dat(ser_dat),
        .ser_en(ser_en), .err_clr(err_clr), .stage_on(stage_on),
        .atten_db(atten_db), .over_range(over_range), .frame_err(frame_err)
    );

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic check_outputs(input string req);
        chk({req, " stage_on"}, stage_on, m_lat);
        chk({req, " atten_db (R6)"}, atten_db, m_lat);
        chk({req, " over_range (R8)"}, over_range, (m_lat > 6'd58));
        chk({req, " frame_err (R9)"}, frame_err, m_err);
    endtask

    // Sends n bits MSB first, then raises enable and waits for the latch (R10).
    task automatic send_frame(input logic [15:0] bits, input int n, input string req);
        ser_en = 1'b0;
        wait_clk(4);
        for (int i = n - 1; i >= 0; i--) begin
            ser_dat = bits[i];
            wait_clk(3);
            ser_clk = 1'b1;
            wait_clk(3);
            ser_clk = 1'b0;
            m_sh = {m_sh[6:0], bits[i]};
        end
        wait_clk(3);
        check_outputs({req, " hold during entry R3"});
        ser_en = 1'b1;
        m_lat = m_sh[5:0];
        if (n != 8) m_err = 1'b1;
        wait_clk(6);
    endtask

    task automatic t_reset;
        check_outputs("R1 reset");
    endtask

    task automatic t_basic;
        send_frame(16'h002A, 8, "R2");
        check_outputs("R2 R4 word 0x2A");
        chk("R4 32dB section on", stage_on[5], 1);
        chk("R4 1dB section bypassed", stage_on[0], 0);
        send_frame(16'h0015, 8, "R2");
        check_outputs("R2 R4 word 0x15");
    endtask

    task automatic t_upper_ignored;
        send_frame(16'h00C5, 8, "R5");
        check_outputs("R5 upper bits ignored");
        chk("R5 value", atten_db, 5);
    endtask

    task automatic t_range;
        send_frame(16'h003A, 8, "R8");
        check_outputs("R8 at 58");
        chk("R8 58 not over", over_range, 0);
        send_frame(16'h003B, 8, "R8");
        chk("R8 59 over", over_range, 1);
        send_frame(16'h003F, 8, "R8");
        check_outputs("R8 R6 at 63");
    endtask

    task automatic t_bad_count;
        send_frame(16'h0307, 10, "R9");
        check_outputs("R9 ten clocks");
        chk("R9 last eight bits", atten_db, 7);
        send_frame(16'h0013, 5, "R9");
        check_outputs("R9 five clocks");
        err_clr = 1'b1;
        wait_clk(1);
        err_clr = 1'b0;
        m_err = 1'b0;
        wait_clk(2);
        check_outputs("R9 after clear");
    endtask

    task automatic t_idle_clocks;
        send_frame(16'h0009, 8, "R7");
        ser_dat = 1'b1;
        for (int i = 0; i < 4; i++) begin
            wait_clk(3);
            ser_clk = 1'b1;
            wait_clk(3);
            ser_clk = 1'b0;
        end
        wait_clk(6);
        check_outputs("R7 idle clocks no output change");
        send_frame(16'h0000, 3, "R7");
        check_outputs("R7 idle clocks did not shift");
        chk("R7 residual word", atten_db, 6'h08);
        err_clr = 1'b1;
        wait_clk(1);
        err_clr = 1'b0;
        m_err = 1'b0;
        wait_clk(2);
    endtask

    initial begin
        wait_clk(3);
        rst_n = 1'b1;
        wait_clk(3);
        t_reset();
        t_basic();
        t_upper_ignored();
        t_range();
        t_bad_count();
        t_idle_clocks();
        check_outputs("R3 final state");
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(20 * 100000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule